// File: doc/BRIEF.md
# Byte-Register Serial Port Front End

This block is the processor-facing side of a simple serial port. It sits on a small byte-wide register bus and maps eight registers onto 4-byte aligned addresses. Each register carries 8 meaningful bits. Software uses these registers to read four identification bytes, to push one transmit character, to pop received characters, to manage interrupt enables and error flags, and to program a 16-bit baud divisor. The serial shifters and the receive FIFO storage sit outside the block.

The transmit side is a single holding slot. A byte written into it is offered to the external transmit engine, and the slot stays busy until that engine reports the byte as sent. The receive side sees the head byte and the fill count of an external FIFO. A read of the data register captures the head byte and pops it from the FIFO. Both directions share one registered interrupt line. The status register mixes read-only flags, two writable enables and two sticky error flags. Software clears an error flag by writing a zero to its bit.

Top module: `uart_regfront`

## Requirements
- R1: After the synchronous reset, STATUS reads 0xA0, `baud_div` is 0, and `irq` and `tx_valid` are 0. The value 0xA0 means transmit-empty and receive-empty are set and every other bit is clear.
- R2: Word offsets 0, 4, 8 and 12 read bytes 0 to 3 of `ID_WORD`, lowest byte first. Writes to these offsets have no effect.
- R3: A write to DATA (offset 16) while transmit-empty (STATUS bit 7) is 1 loads the byte into `tx_byte` and raises `tx_valid` on the next cycle. It also clears bit 7. Bit 7 and `tx_valid` stay in that state until a `tx_done` pulse.
- R4: A write to DATA while the slot is busy is ignored. `tx_byte` keeps its earlier value.
- R5: A read of DATA with a non-empty FIFO returns the head byte and pulses `rx_pop` in the same cycle. A read of DATA with an empty FIFO returns the byte most recently popped and does not pulse `rx_pop`.
- R6: STATUS flags follow the FIFO count. Bit 5 is set when the count is 0. Bit 4 is set when the count is `RX_DEPTH-1`. Bit 3 is set when the count is `RX_DEPTH`.
- R7: A pulse on `rx_frame_err` sets STATUS bit 0, and a pulse on `rx_overrun` sets bit 1. Writing STATUS with a 0 in one of these bits clears that flag. Writing a 1 leaves the flag unchanged and never sets it.
- R8: `irq` is registered. It equals (bit 2 AND (count nonzero OR bit 0 OR bit 1)) OR (bit 6 AND bit 7), evaluated on the state of the previous cycle.
- R9: BAUDL (offset 24) and BAUDH (offset 28) hold the low and high bytes of `baud_div`. Both read back what was written.
- R10: STATUS bits 2 (receive interrupt enable) and 6 (transmit interrupt enable) store written values. Written values on bits 3, 4, 5 and 7 are ignored.
- R11: An access with nonzero address bits [1:0], or with nonzero address bits above bit 4, does not write anything and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| rx_byte | input | 8 | Head byte of the external receive FIFO |
| rx_count | input | $clog2(RX_DEPTH+1) | Receive FIFO fill count |
| rx_pop | output | 1 | Removes the head byte from the FIFO |
| rx_frame_err | input | 1 | Pulse: stop bit missing |
| rx_overrun | input | 1 | Pulse: byte lost because the FIFO was full |
| tx_byte | output | 8 | Byte held in the transmit slot |
| tx_valid | output | 1 | Transmit slot holds a byte |
| tx_done | input | 1 | Pulse: transmit engine finished the byte |
| baud_div | output | 16 | Baud divisor |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `ADDR_W` = 6, `RX_DEPTH` = 4 and a fixed `ID_WORD`. The extra address bit puts an out-of-window alias of every register within reach, which exercises the address-miss path of R11. With a depth of four, the FIFO can be stepped through every fill level, from empty through one-slot-left to full, so each flag combination of R6 is checked. The small depth also makes it possible to sweep every pairing of the two enables, pending data, pending error and transmit-empty against the interrupt equation. A full sweep over all 256 byte values on both divisor registers completes the coverage.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int NUM_REGS = 8;
  localparam int LOW_W    = 5;

  typedef enum logic [2:0] {
    SEL_ID0  = 3'd0,
    SEL_ID1  = 3'd1,
    SEL_ID2  = 3'd2,
    SEL_ID3  = 3'd3,
    SEL_DATA = 3'd4,
    SEL_STAT = 3'd5,
    SEL_DIVL = 3'd6,
    SEL_DIVH = 3'd7
  } reg_sel_e;

  localparam int B_FRAME   = 0;
  localparam int B_OVER    = 1;
  localparam int B_RXIE    = 2;
  localparam int B_FULL    = 3;
  localparam int B_ROOM1   = 4;
  localparam int B_RXEMPTY = 5;
  localparam int B_TXIE    = 6;
  localparam int B_TXEMPTY = 7;
endpackage

// File: rtl/urf_decode.sv
module urf_decode #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr,
  input  logic                        rd,
  output logic [urf_pkg::NUM_REGS-1:0] wr_en,
  output logic [urf_pkg::NUM_REGS-1:0] rd_en
);
  import urf_pkg::*;

  logic in_window;
  logic aligned;
  logic [2:0] idx;

  generate
    if (ADDR_W > LOW_W) begin : g_upper
      assign in_window = (addr[ADDR_W-1:LOW_W] == '0);
    end else begin : g_flat
      assign in_window = 1'b1;
    end
  endgenerate

  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = addr[4:2];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign wr_en[i] = wr & in_window & aligned & (idx == 3'(i));
      assign rd_en[i] = rd & in_window & aligned & (idx == 3'(i));
    end
  endgenerate
endmodule

// File: rtl/urf_divisor.sv
module urf_divisor #(
  parameter int NBYTES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NBYTES-1:0]     wr_byte,
  input  logic [7:0]            wdata,
  output logic [8*NBYTES-1:0]   divisor
);
  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)             divisor[8*b +: 8] <= 8'h00;
        else if (wr_byte[b]) divisor[8*b +: 8] <= wdata;
      end
    end
  endgenerate

  AST_DIV_LOW: assert property (@(posedge clk) disable iff (rst)
    wr_byte[0] |=> divisor[7:0] == $past(wdata)); // R9
endmodule

// File: rtl/urf_status.sv
module urf_status #(
  parameter int RX_DEPTH = 4,
  parameter int CNT_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stat,
  input  logic             wr_data,
  input  logic [7:0]       wdata,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_frame_err,
  input  logic             rx_overrun,
  input  logic             tx_done,
  output logic [7:0]       status,
  output logic [7:0]       tx_byte,
  output logic             tx_valid,
  output logic             irq
);
  import urf_pkg::*;

  logic rxie, txie, frame, over, txe;
  logic rx_any, rx_full, rx_room1;

  assign rx_any   = (rx_count != '0);
  assign rx_full  = (rx_count == CNT_W'(RX_DEPTH));
  assign rx_room1 = (rx_count == CNT_W'(RX_DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rxie <= 1'b0;
      txie <= 1'b0;
    end else if (wr_stat) begin
      rxie <= wdata[B_RXIE];
      txie <= wdata[B_TXIE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= 1'b0;
      over  <= 1'b0;
    end else begin
      frame <= rx_frame_err | (frame & ~(wr_stat & ~wdata[B_FRAME]));
      over  <= rx_overrun   | (over  & ~(wr_stat & ~wdata[B_OVER]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txe     <= 1'b1;
      tx_byte <= 8'h00;
    end else if (txe && wr_data) begin
      txe     <= 1'b0;
      tx_byte <= wdata;
    end else if (!txe && tx_done) begin
      txe     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (rxie & (rx_any | frame | over)) | (txie & txe);
  end

  assign tx_valid = ~txe;

  always_comb begin
    status            = 8'h00;
    status[B_FRAME]   = frame;
    status[B_OVER]    = over;
    status[B_RXIE]    = rxie;
    status[B_FULL]    = rx_full;
    status[B_ROOM1]   = rx_room1;
    status[B_RXEMPTY] = ~rx_any;
    status[B_TXIE]    = txie;
    status[B_TXEMPTY] = txe;
  end

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !tx_valid) |=> (tx_valid && tx_byte == $past(wdata))); // R3
  AST_TX_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_valid && !tx_done) |=> $stable(tx_byte)); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |=> status[B_FRAME]); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wdata[B_FRAME] && !rx_frame_err) |=> !status[B_FRAME]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!status[B_RXIE] && !status[B_TXIE]) |=> !irq); // R8
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int          ADDR_W   = 5,
  parameter int          RX_DEPTH = 4,
  parameter logic [31:0] ID_WORD  = 32'h5AC3_0001
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [7:0]                     bus_wdata,
  output logic [7:0]                     bus_rdata,
  input  logic [7:0]                     rx_byte,
  input  logic [$clog2(RX_DEPTH+1)-1:0]  rx_count,
  output logic                           rx_pop,
  input  logic                           rx_frame_err,
  input  logic                           rx_overrun,
  output logic [7:0]                     tx_byte,
  output logic                           tx_valid,
  input  logic                           tx_done,
  output logic [15:0]                    baud_div,
  output logic                           irq
);
  import urf_pkg::*;

  localparam int CNT_W  = $clog2(RX_DEPTH + 1);
  localparam int NBYTES = 2;

  logic [NUM_REGS-1:0] wr_en, rd_en;
  logic [7:0] status;
  logic [7:0] last_rx;
  logic [7:0] rd_val;

  urf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .wr_en(wr_en),
    .rd_en(rd_en)
  );

  urf_status #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .wr_stat     (wr_en[SEL_STAT]),
    .wr_data     (wr_en[SEL_DATA]),
    .wdata       (bus_wdata),
    .rx_count    (rx_count),
    .rx_frame_err(rx_frame_err),
    .rx_overrun  (rx_overrun),
    .tx_done     (tx_done),
    .status      (status),
    .tx_byte     (tx_byte),
    .tx_valid    (tx_valid),
    .irq         (irq)
  );

  urf_divisor #(.NBYTES(NBYTES)) u_div (
    .clk    (clk),
    .rst    (rst),
    .wr_byte({wr_en[SEL_DIVH], wr_en[SEL_DIVL]}),
    .wdata  (bus_wdata),
    .divisor(baud_div)
  );

  assign rx_pop = rd_en[SEL_DATA] & (rx_count != '0);

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < 4; i++) begin
      if (rd_en[i]) rd_val = ID_WORD[8*i +: 8];
    end
    if (rd_en[SEL_DATA]) rd_val = rx_pop ? rx_byte : last_rx;
    if (rd_en[SEL_STAT]) rd_val = status;
    if (rd_en[SEL_DIVL]) rd_val = baud_div[7:0];
    if (rd_en[SEL_DIVH]) rd_val = baud_div[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      last_rx   <= 8'h00;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      if (rx_pop) last_rx   <= rx_byte;
    end
  end

  AST_POP_RDATA: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> bus_rdata == $past(rx_byte)); // R5
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |-> !rx_pop); // R5
endmodule

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;
  localparam int          AW    = 6;
  localparam int          DEPTH = 4;
  localparam logic [31:0] IDW   = 32'h5AC3_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] rx_byte;
  logic [2:0] rx_count;
  logic rx_pop;
  logic rx_frame_err = 1'b0, rx_overrun = 1'b0, tx_done = 1'b0;
  logic [7:0] tx_byte;
  logic tx_valid;
  logic [15:0] baud_div;
  logic irq;

  int nchk = 0, nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_regfront #(.ADDR_W(AW), .RX_DEPTH(DEPTH), .ID_WORD(IDW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte(rx_byte),
    .rx_count(rx_count), .rx_pop(rx_pop), .rx_frame_err(rx_frame_err),
    .rx_overrun(rx_overrun), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_done(tx_done), .baud_div(baud_div), .irq(irq));

  // external receive FIFO model
  logic [7:0] q [0:DEPTH-1];
  logic [2:0] qn = 3'd0;
  logic push_req = 1'b0;
  logic [7:0] push_val = 8'h00;
  assign rx_byte  = q[0];
  assign rx_count = qn;

  initial for (int i = 0; i < DEPTH; i++) q[i] = 8'h00;

  always @(posedge clk) begin
    if (rx_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) q[i] <= q[i+1];
      qn <= qn - 3'd1;
    end else if (push_req) begin
      q[qn[1:0]] <= push_val;
      qn <= qn + 3'd1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk);
    push_req = 1'b1; push_val = v;
    @(negedge clk);
    push_req = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); rx_frame_err = 1'b1; @(negedge clk); rx_frame_err = 1'b0;
  endtask
  task automatic pulse_over();
    @(negedge clk); rx_overrun = 1'b1; @(negedge clk); rx_overrun = 1'b0;
  endtask
  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask

  function automatic logic [7:0] exp_stat(input bit rxie, input bit txie, input bit fr,
                                          input bit ov, input int cnt, input bit txe);
    logic [7:0] s;
    s = 8'h00;
    s[0] = fr; s[1] = ov; s[2] = rxie;
    s[3] = (cnt == DEPTH); s[4] = (cnt == DEPTH - 1); s[5] = (cnt == 0);
    s[6] = txie; s[7] = txe;
    return s;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    bit b_txe;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    check("R1 baud_div", 32'(baud_div), 0);
    rd(20, v); check("R1 status", 32'(v), 32'hA0);

    // R2 identification bytes, read-only
    for (int i = 0; i < 4; i++) begin
      rd(4*i, v); check("R2 id read", 32'(v), 32'(IDW[8*i +: 8]));
      wr(4*i, ~IDW[8*i +: 8]);
      rd(4*i, v); check("R2 id after write", 32'(v), 32'(IDW[8*i +: 8]));
    end

    // R9 divisor sweep over every byte value
    for (int k = 0; k < 256; k++) begin
      wr(24, 8'(k)); wr(28, 8'(255 - k));
      check("R9 baud_div", 32'(baud_div), 32'(((255 - k) << 8) | k));
      rd(24, v); check("R9 low readback", 32'(v), 32'(k));
      rd(28, v); check("R9 high readback", 32'(v), 32'(255 - k));
    end

    // R11 out-of-window and misaligned accesses
    wr(24, 8'h12); wr(28, 8'h34);
    wr(32 + 24, 8'h77); wr(25, 8'h66); wr(32 + 28, 8'h55);
    check("R11 no write", 32'(baud_div), 32'h3412);
    rd(32 + 20, v); check("R11 miss read", 32'(v), 0);
    rd(26, v); check("R11 misaligned read", 32'(v), 0);

    // R3 / R4 transmit slot
    wr(16, 8'h5A);
    check("R3 tx_valid", 32'(tx_valid), 1);
    check("R3 tx_byte", 32'(tx_byte), 32'h5A);
    rd(20, v); check("R3 txe clear", 32'(v[7]), 0);
    wr(16, 8'h33);
    check("R4 busy write ignored", 32'(tx_byte), 32'h5A);
    repeat (3) @(negedge clk);
    check("R3 held busy", 32'(tx_valid), 1);
    pulse_done();
    check("R3 slot free", 32'(tx_valid), 0);
    rd(20, v); check("R3 txe set", 32'(v[7]), 1);
    wr(16, 8'hC7);
    check("R3 reload", 32'(tx_byte), 32'hC7);
    pulse_done();

    // R6 / R5 receive fill levels and pops
    for (int n = 0; n <= DEPTH; n++) begin
      rd(20, v); check("R6 status at fill", 32'(v), 32'(exp_stat(0, 0, 0, 0, n, 1)));
      if (n < DEPTH) push(8'(8'h40 + n));
    end
    for (int n = 0; n < DEPTH; n++) begin
      rd(16, v); check("R5 pop order", 32'(v), 32'(8'h40 + n));
      check("R5 count after pop", 32'(rx_count), 32'(DEPTH - 1 - n));
    end
    rd(16, v); check("R5 empty read", 32'(v), 32'h43);
    check("R5 empty no pop", 32'(rx_count), 0);

    // R10 enables store, flag bits ignore writes
    wr(20, 8'hFF);
    rd(20, v); check("R10 all ones", 32'(v), 32'(exp_stat(1, 1, 0, 0, 0, 1)));
    wr(20, 8'h00);
    rd(20, v); check("R10 all zeros", 32'(v), 32'(exp_stat(0, 0, 0, 0, 0, 1)));

    // R7 error flags
    pulse_frame(); pulse_over();
    rd(20, v); check("R7 both set", 32'(v), 32'(exp_stat(0, 0, 1, 1, 0, 1)));
    wr(20, v);
    rd(20, v); check("R7 rmw keeps", 32'(v), 32'(exp_stat(0, 0, 1, 1, 0, 1)));
    wr(20, 8'hFE);
    rd(20, v); check("R7 frame cleared", 32'(v), 32'(exp_stat(1, 1, 0, 1, 0, 1)));
    wr(20, 8'h01);
    rd(20, v); check("R7 over cleared, one no set", 32'(v), 32'(exp_stat(0, 0, 0, 0, 0, 1)));

    // R8 interrupt sweep
    b_txe = 1'b1;
    for (int e = 0; e < 4; e++)
      for (int p = 0; p < 2; p++)
        for (int t = 0; t < 2; t++)
          for (int f = 0; f < 2; f++) begin
            while (qn != 0) rd(16, v);
            if (t == 1 && !b_txe) begin pulse_done(); b_txe = 1'b1; end
            if (t == 0 && b_txe)  begin wr(16, 8'hA5); b_txe = 1'b0; end
            wr(20, 8'((((e >> 1) & 1) << 6) | ((e & 1) << 2)));
            if (p == 1) push(8'h99);
            if (f == 1) pulse_frame();
            @(negedge clk);
            check("R8 irq", 32'(irq),
                  32'(((e & 1) & (p | f)) | (((e >> 1) & 1) & t)));
          end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule